// File: doc/BRIEF.md
# Pulse-Count Burst Encoder

This block produces the command stream for a simple infrared remote link, where a command is identified only by how many pulses a burst contains. A divider turns the system clock into a slow square pulse clock. Each full pulse period steps a sequencing counter. The first two counter states hold the output dark, and this dark time is the gap between bursts. In every later state one positive pulse passes.

Seven command buttons select how far the counter runs before it wraps to zero. With command k held, a burst carries exactly k pulses. With no button held, the counter runs its full length and sends an eight-pulse idle burst, which a receiver reads as "no command". The burst repeats for as long as the selection stays the same. A second output gates a fast carrier square wave with the burst, ready for an emitter driver. The buttons are synchronised and priority-encoded. A new selection takes effect only when the counter wraps to state zero, so a burst is never cut short.

Top module: `ir_burst_encoder`

## Requirements
- R1: While `rst` is high, and for the first three pulse half-periods after it falls, `burstOut` and `carrierOut` are 0. After reset the sequencer is in state 0 with no command selected.
- R2: Each pulse inside a burst is high for exactly `PULSE_HALF_DIV` clock cycles. Two pulses in the same burst are separated by a low time of exactly `PULSE_HALF_DIV` cycles.
- R3: With no button held, every burst holds 8 pulses (`IDLE_PULSES`).
- R4: With only button bit k-1 of `cmdButtons` held (bit 0 is command 1, bit 6 is command 7), every burst holds exactly k pulses.
- R5: The low time between the last pulse of one burst and the first pulse of the next is exactly (2*`GAP_STATES`+1)*`PULSE_HALF_DIV` cycles, whatever the command.
- R6: When several buttons are held together, the command with the lowest number is sent.
- R7: A button change that arrives during a burst has no effect on that burst. It first applies to the burst that follows the next wrap to state 0.
- R8: `carrierOut` is high only in cycles where `burstOut` is high. During a pulse it toggles every `CARRIER_HALF_DIV` cycles.
- R9: While the selection stays the same, bursts of the same length repeat back to back without end.
- R10: The sequencing counter never goes past state `GAP_STATES`+`IDLE_PULSES`-1. It advances by one step, or wraps to 0, once per pulse period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdButtons | input | NUM_CMDS | Command buttons, bit i selects command i+1, active high, asynchronous |
| burstOut | output | 1 | Registered positive pulse train, bursts of pulses |
| carrierOut | output | 1 | Registered carrier, gated by the burst pulses |

## Verification
The hardest case to reach from the ports is a button change that lands in the middle of a burst. It has to be shown that the running burst still finishes at its old length and that the very next burst takes the new one. The bench first locks onto the burst framing by waiting for a dark run longer than any gap inside a burst. It then counts pulses edge by edge and changes the buttons right after a chosen pulse number. It measures the same burst to its end and then goes straight on to the next burst without resynchronising. Priority is covered with several overlapping button patterns. Each length is checked only after enough bursts have passed for the new selection to take effect.

// File: rtl/ibe_pkg.sv
package ibe_pkg;

  // Strobes from the sequencing control to the pulse datapath
  typedef struct packed {
    logic gateOpen;   // counter is in a pulse-passing state
    logic wrapNow;    // counter returns to state 0 on this period start
  } seqStrobe_t;

  // Timing information from the datapath back to control
  typedef struct packed {
    logic periodStart; // pulse clock is about to rise
    logic phaseHigh;   // pulse clock currently high
  } timeTick_t;

endpackage

// File: rtl/ibe_button_sel.sv
module ibe_button_sel #(
  parameter int NUM_CMDS    = 7,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W      = $clog2(NUM_CMDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CMDS-1:0] buttonsAsync,
  output logic [CMD_W-1:0]    selCmd
);

  logic [NUM_CMDS-1:0] stageReg [SYNC_STAGES];

  // Synchroniser chain, one register stage per parameter step
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stageReg[s] <= '0;
          else     stageReg[s] <= buttonsAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stageReg[s] <= '0;
          else     stageReg[s] <= stageReg[s-1];
        end
      end
    end
  endgenerate

  // Lowest-numbered held button wins; 0 means idle
  always_comb begin
    selCmd = '0;
    for (int i = NUM_CMDS - 1; i >= 0; i--) begin
      if (stageReg[SYNC_STAGES-1][i]) selCmd = CMD_W'(i + 1);
    end
  end

endmodule

// File: rtl/ibe_seq_ctrl.sv
module ibe_seq_ctrl
  import ibe_pkg::*;
#(
  parameter int NUM_CMDS    = 7,
  parameter int GAP_STATES  = 2,
  parameter int IDLE_PULSES = 8,
  localparam int CMD_W      = $clog2(NUM_CMDS + 1),
  localparam int IDLE_LIMIT = GAP_STATES + IDLE_PULSES,
  localparam int CNT_W      = $clog2(IDLE_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  timeTick_t        tick,
  input  logic [CMD_W-1:0] selCmd,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] seqCount,
  output logic [CMD_W-1:0] activeCmd
);

  logic [CNT_W-1:0] lastState;

  // Final state of the current burst; command k ends at state k+GAP-1
  always_comb begin
    if (activeCmd == '0) lastState = CNT_W'(IDLE_LIMIT - 1);
    else                 lastState = CNT_W'(activeCmd) + CNT_W'(GAP_STATES - 1);
  end

  always_comb begin
    strobe.gateOpen = (seqCount >= CNT_W'(GAP_STATES));
    strobe.wrapNow  = tick.periodStart && (seqCount == lastState);
  end

  // Counter steps once per pulse period; command latched only on wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      seqCount  <= '0;
      activeCmd <= '0;
    end else if (tick.periodStart) begin
      if (strobe.wrapNow) begin
        seqCount  <= '0;
        activeCmd <= selCmd;
      end else begin
        seqCount  <= seqCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ibe_pulse_dp.sv
module ibe_pulse_dp
  import ibe_pkg::*;
#(
  parameter int PULSE_HALF_DIV   = 2500,
  parameter int CARRIER_HALF_DIV = 18,
  parameter bit CARRIER_EN       = 1'b1,
  localparam int HALF_W = (PULSE_HALF_DIV > 1) ? $clog2(PULSE_HALF_DIV) : 1,
  localparam int CAR_W  = (CARRIER_HALF_DIV > 1) ? $clog2(CARRIER_HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output timeTick_t  tick,
  output logic       burstOut,
  output logic       carrierOut
);

  logic [HALF_W-1:0] halfCnt;
  logic              halfTick;
  logic              pulsePhase;

  assign halfTick = (halfCnt == HALF_W'(PULSE_HALF_DIV - 1));

  // Pulse clock: square wave of period 2*PULSE_HALF_DIV, starts low
  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt    <= '0;
      pulsePhase <= 1'b0;
    end else if (halfTick) begin
      halfCnt    <= '0;
      pulsePhase <= ~pulsePhase;
    end else begin
      halfCnt    <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    tick.periodStart = halfTick && !pulsePhase;
    tick.phaseHigh   = pulsePhase;
  end

  // Registered gated pulse train
  always_ff @(posedge clk) begin
    if (rst) burstOut <= 1'b0;
    else     burstOut <= strobe.gateOpen && pulsePhase;
  end

  generate
    if (CARRIER_EN) begin : g_carrier
      logic [CAR_W-1:0] carCnt;
      logic             carPhase;

      always_ff @(posedge clk) begin
        if (rst) begin
          carCnt   <= '0;
          carPhase <= 1'b0;
        end else if (carCnt == CAR_W'(CARRIER_HALF_DIV - 1)) begin
          carCnt   <= '0;
          carPhase <= ~carPhase;
        end else begin
          carCnt   <= carCnt + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) carrierOut <= 1'b0;
        else     carrierOut <= strobe.gateOpen && pulsePhase && carPhase;
      end
    end else begin : g_no_carrier
      always_ff @(posedge clk) begin
        carrierOut <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/ir_burst_encoder.sv
module ir_burst_encoder
  import ibe_pkg::*;
#(
  parameter int NUM_CMDS         = 7,
  parameter int GAP_STATES       = 2,
  parameter int IDLE_PULSES      = 8,
  parameter int PULSE_HALF_DIV   = 2500,
  parameter int CARRIER_HALF_DIV = 18,
  parameter bit CARRIER_EN       = 1'b1,
  parameter int SYNC_STAGES      = 2,
  localparam int CMD_W      = $clog2(NUM_CMDS + 1),
  localparam int IDLE_LIMIT = GAP_STATES + IDLE_PULSES,
  localparam int CNT_W      = $clog2(IDLE_LIMIT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CMDS-1:0] cmdButtons,
  output logic                burstOut,
  output logic                carrierOut
);

  logic [CMD_W-1:0] selCmd;
  logic [CMD_W-1:0] activeCmd;
  logic [CNT_W-1:0] seqCount;
  seqStrobe_t       strobe;
  timeTick_t        tick;

  ibe_button_sel #(
    .NUM_CMDS   (NUM_CMDS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_btn (
    .clk         (clk),
    .rst         (rst),
    .buttonsAsync(cmdButtons),
    .selCmd      (selCmd)
  );

  ibe_seq_ctrl #(
    .NUM_CMDS   (NUM_CMDS),
    .GAP_STATES (GAP_STATES),
    .IDLE_PULSES(IDLE_PULSES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .selCmd   (selCmd),
    .strobe   (strobe),
    .seqCount (seqCount),
    .activeCmd(activeCmd)
  );

  ibe_pulse_dp #(
    .PULSE_HALF_DIV  (PULSE_HALF_DIV),
    .CARRIER_HALF_DIV(CARRIER_HALF_DIV),
    .CARRIER_EN      (CARRIER_EN)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .tick      (tick),
    .burstOut  (burstOut),
    .carrierOut(carrierOut)
  );

endmodule

// File: rtl/ibe_checker.sv
module ibe_checker #(
  parameter int NUM_CMDS    = 7,
  parameter int GAP_STATES  = 2,
  parameter int IDLE_PULSES = 8,
  localparam int CMD_W      = $clog2(NUM_CMDS + 1),
  localparam int IDLE_LIMIT = GAP_STATES + IDLE_PULSES,
  localparam int CNT_W      = $clog2(IDLE_LIMIT)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] seqCount,
  input logic [CMD_W-1:0] activeCmd,
  input logic             burstOut,
  input logic             carrierOut
);

  // R10: counter stays inside the idle cycle length
  assert_count_range_R10: assert property (@(posedge clk) disable iff (rst)
    int'(seqCount) < IDLE_LIMIT);

  // R10: counter holds, steps by one, or wraps to zero
  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    (seqCount != $past(seqCount)) |->
      ((int'(seqCount) == int'($past(seqCount)) + 1) || (seqCount == '0)));

  // R8: carrier never appears outside a pulse
  assert_carrier_inside_R8: assert property (@(posedge clk) disable iff (rst)
    carrierOut |-> burstOut);

  // R5: blanking states keep the output dark one cycle later
  assert_gap_dark_R5: assert property (@(posedge clk) disable iff (rst)
    (int'($past(seqCount)) < GAP_STATES) |-> !burstOut);

  // R7: selected command only changes when the counter lands on state 0
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (activeCmd != $past(activeCmd)) |-> (seqCount == '0));

  // R4: a wrap occurs only from the last state belonging to the held command
  assert_wrap_point_R4: assert property (@(posedge clk) disable iff (rst)
    (($past(seqCount) != '0) && (seqCount == '0)) |->
      (int'($past(seqCount)) + 1 ==
        (($past(activeCmd) == '0) ? IDLE_LIMIT
                                  : int'($past(activeCmd)) + GAP_STATES)));

endmodule

bind ir_burst_encoder ibe_checker #(
  .NUM_CMDS   (NUM_CMDS),
  .GAP_STATES (GAP_STATES),
  .IDLE_PULSES(IDLE_PULSES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seqCount  (seqCount),
  .activeCmd (activeCmd),
  .burstOut  (burstOut),
  .carrierOut(carrierOut)
);

// File: tb/ir_burst_encoder_tb.sv
module ir_burst_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int CAR_HALF   = 1;
  localparam int GAP        = 2;
  localparam int IDLE_N     = 8;
  localparam int GAP_LEN    = (2 * GAP + 1) * HALF;
  localparam int GAP_THRESH = 2 * HALF + 2;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] buttons = '0;
  logic       burstOut;
  logic       carrierOut;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  ir_burst_encoder #(
    .NUM_CMDS        (7),
    .GAP_STATES      (GAP),
    .IDLE_PULSES     (IDLE_N),
    .PULSE_HALF_DIV  (HALF),
    .CARRIER_HALF_DIV(CAR_HALF),
    .CARRIER_EN      (1'b1),
    .SYNC_STAGES     (2)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmdButtons(buttons),
    .burstOut  (burstOut),
    .carrierOut(carrierOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Measures one burst. Without skipSync it first waits for a gap.
  // After pulse number changeAfter the buttons are set to newBtn.
  task automatic measureBurst(input bit skipSync, input int changeAfter,
                              input logic [6:0] newBtn,
                              output int pulses, output int gapLen,
                              output int badWidth, output int carHigh,
                              output int carStray);
    int run;
    pulses = 0; gapLen = 0; badWidth = 0; carHigh = 0; carStray = 0;
    if (!skipSync) begin
      run = 0;
      while (run < GAP_THRESH) begin
        @(negedge clk);
        if (!burstOut) run++; else run = 0;
      end
      while (!burstOut) @(negedge clk);
    end
    forever begin
      int hl;
      int ll;
      hl = 0;
      while (burstOut) begin
        hl++;
        if (carrierOut) carHigh++;
        @(negedge clk);
      end
      pulses++;
      if (hl != HALF) badWidth++;
      if (pulses == changeAfter) buttons = newBtn;
      ll = 0;
      while (!burstOut) begin
        ll++;
        if (carrierOut) carStray++;
        @(negedge clk);
      end
      if (ll > GAP_THRESH) begin
        gapLen = ll;
        break;
      end
      if (ll != HALF) badWidth++;
    end
  endtask

  task automatic skipBursts(input int n);
    int p, g, b, c, s;
    for (int i = 0; i < n; i++) measureBurst(1'b0, 0, buttons, p, g, b, c, s);
  endtask

  task automatic testReset();
    int highSeen;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 burstOut in reset", int'(burstOut), 0);
    check("R1 carrierOut in reset", int'(carrierOut), 0);
    rst = 1'b0;
    highSeen = 0;
    for (int i = 0; i < 3 * HALF; i++) begin
      @(negedge clk);
      if (burstOut || carrierOut) highSeen++;
    end
    check("R1 dark after reset", highSeen, 0);
  endtask

  task automatic testIdle();
    int p, g, b, c, s;
    buttons = '0;
    for (int i = 0; i < 3; i++) begin
      measureBurst(1'b0, 0, buttons, p, g, b, c, s);
      check("R3 idle pulse count", p, IDLE_N);
      check("R5 idle gap length", g, GAP_LEN);
      check("R2 pulse and space widths", b, 0);
      check("R8 carrier outside pulse", s, 0);
      check("R8 carrier present", int'(c > 0), 1);
    end
  endtask

  task automatic testCommands();
    int p, g, b, c, s;
    for (int k = 1; k <= 7; k++) begin
      buttons = 7'(1 << (k - 1));
      skipBursts(2);
      for (int r = 0; r < 2; r++) begin
        measureBurst(1'b0, 0, buttons, p, g, b, c, s);
        check("R4 command pulse count", p, k);
        check("R5 command gap length", g, GAP_LEN);
        check("R2 command widths", b, 0);
        check("R8 command carrier stray", s, 0);
      end
      // R9: back-to-back repeat, measured without resync
      measureBurst(1'b1, 0, buttons, p, g, b, c, s);
      check("R9 repeated burst", p, k);
    end
  endtask

  task automatic testPriority();
    int p, g, b, c, s;
    buttons = 7'b0110100;
    skipBursts(2);
    measureBurst(1'b0, 0, buttons, p, g, b, c, s);
    check("R6 cmds 3,5,6 held", p, 3);
    buttons = 7'b1111111;
    skipBursts(2);
    measureBurst(1'b0, 0, buttons, p, g, b, c, s);
    check("R6 all held", p, 1);
    buttons = 7'b1000010;
    skipBursts(2);
    measureBurst(1'b0, 0, buttons, p, g, b, c, s);
    check("R6 cmds 2,7 held", p, 2);
  endtask

  task automatic testMidBurstChange();
    int p, g, b, c, s;
    buttons = '0;
    skipBursts(2);
    measureBurst(1'b0, 3, 7'b0010000, p, g, b, c, s);
    check("R7 idle burst kept after change", p, IDLE_N);
    measureBurst(1'b1, 0, buttons, p, g, b, c, s);
    check("R7 next burst takes cmd 5", p, 5);
    measureBurst(1'b1, 2, 7'b0000000, p, g, b, c, s);
    check("R7 cmd 5 burst kept after release", p, 5);
    measureBurst(1'b1, 0, buttons, p, g, b, c, s);
    check("R7 next burst back to idle", p, IDLE_N);
    measureBurst(1'b1, 1, 7'b0000001, p, g, b, c, s);
    check("R7 idle kept when cmd 1 pressed", p, IDLE_N);
    measureBurst(1'b1, 0, buttons, p, g, b, c, s);
    check("R7 next burst takes cmd 1", p, 1);
  endtask

  initial begin
    while (cycles < WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testIdle();
    testCommands();
    testPriority();
    testMidBurstChange();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule